// File: doc/BRIEF.md
# Flash Read-Path Power-Mode Controller

This block is the clocked read-side controller of a parallel NOR-style flash device. It watches chip select, output enable, an active-low device reset, a byte/word width select and the address bus. From these it decides when read data may be presented on the tri-state data pins. It also tracks which of four power states the device is in: active, standby, sleep or waking. The cell array sits outside the block and is reached through a plain combinational memory port: the block drives a word address and receives the word in the same cycle.

A read starts when the sampled address (with the width select) changes, or when the device becomes selected. The word is captured into an output latch a fixed number of clock cycles later. Once the address has stayed unchanged long enough, the block drops into automatic sleep and keeps presenting the latched word. Holding the device reset low forces standby, and releasing it starts a timed wake-up. Straight after power-up, an unchanged address yields no valid data until a reset pulse, a chip-select transition or an address change has occurred. A combinational decode also reports which erase sector the current address falls in, for either a top or a bottom boot layout.

All delays are given in nanoseconds and converted to cycle counts with the clock period: ACC_CYC for access, OE_CYC for output enable, RH_CYC for wake-up and SLP_CYC for the sleep threshold. With the defaults these are 7, 3, 5 and 15. `dq_out` with `data_valid` is a stream with no ready input, because pins cannot push back. A consumer takes the word in any cycle where `data_valid` is high. The memory port is assumed always ready and has no back-pressure.

Top module: `flash_read_pm`

## Requirements
- R1: While `rst_n` is low and right after it, `pwr_state` is 1 (standby), and `data_valid` and `dq_oe` are 0.
- R2: `dq_oe` is high only while `chip_sel`, `out_en` and `dev_rst_n` are high and `data_valid` is high. Dropping any of the three inputs clears `dq_oe` in the same cycle, without waiting for a clock edge.
- R3: When `data_valid` is already high, `dq_oe` rises on the OE_CYC-th rising edge that samples `out_en` (and `chip_sel`) high.
- R4: A read starts at the edge that samples a new address/width value, or at the edge that enters the active state. `data_valid` rises ACC_CYC edges after that start edge, and `dq_out` then holds the memory word for the address.
- R5: An edge that samples `chip_sel` low while `dev_rst_n` is high sets `pwr_state` to 1 and clears `data_valid`. An edge that samples it high again starts a read (R4).
- R6: An edge that samples `dev_rst_n` low sets `pwr_state` to 1 whatever `chip_sel` is. After release, `pwr_state` is 3 (waking) for RH_CYC cycles, with no valid data. After that the block goes active and starts a read.
- R7: With valid data and the address unchanged, `pwr_state` becomes 2 (sleep) SLP_CYC edges after the read start. During sleep `data_valid` stays high, `dq_out` does not change, and `dq_oe` still follows R2. Without valid data the block stays active.
- R8: An edge that samples an address change during sleep returns `pwr_state` to 0 and clears `data_valid`. A new read for the new address then follows R4.
- R9: After `rst_n`, reads at an address held unchanged give no valid data until a device-reset pulse, a `chip_sel` transition or an address change occurs.
- R10: In word mode (`byte_mode`=0), `mem_addr` is `addr[ADDR_W-1:0]`, `addr[ADDR_W]` is ignored, and `dq_out` is the whole word. In byte mode, `mem_addr` is `addr[ADDR_W:1]` and `addr[0]` picks the lane (0 = low byte, 1 = high byte). `dq_out` is then zero-extended from that byte.
- R11: `sector_idx` decodes the word address (`mem_addr`) into the 16 slots of 2^(ADDR_W-4) words each. For the default ADDR_W=19: with bottom boot, word addresses below 0x2000 are sector 0, below 0x3000 sector 1, below 0x4000 sector 2, below 0x8000 sector 3, and anything else is 3 plus `addr>>15`. With top boot (BOOT_TOP=1), addresses below 0x78000 are `addr>>15`, below 0x7C000 are 15, below 0x7D000 are 16, below 0x7E000 are 17, and anything else is 18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| chip_sel | input | 1 | Device select, active high |
| out_en | input | 1 | Output enable, active high |
| dev_rst_n | input | 1 | Device reset pin, active low (standby and wake-up) |
| byte_mode | input | 1 | 1 = byte-wide reads, 0 = word-wide reads |
| addr | input | ADDR_W+1 | Address; bit 0 is the byte-lane bit in byte mode |
| mem_addr | output | ADDR_W | Word address to the array |
| mem_rdata | input | DATA_W | Word returned by the array in the same cycle |
| dq_out | output | DATA_W | Latched read data |
| dq_oe | output | 1 | Drive enable for the data pins |
| data_valid | output | 1 | `dq_out` holds a completed read |
| pwr_state | output | 2 | 0 active, 1 standby, 2 sleep, 3 waking |
| sector_idx | output | 5 | Erase-sector index of the current address |

## Verification
The hardest condition to reach from the pins is the power-up rule of R9. It only applies to the first access after `rst_n`, with chip select and the address both steady. The bench therefore asserts `rst_n` with `chip_sel` already high and holds the address through and past the release. It waits longer than both the access and the sleep thresholds to show that the block stays active without valid data. It then repeats power-up and breaks the rule with a device-reset pulse alone, so that the wake-up path is also the arming path. Random address runs with random hold times fall on either side of the sleep threshold and mix byte and word mode.

// File: rtl/frp_pkg.sv
package frp_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'd0,
    PS_STANDBY = 2'd1,
    PS_SLEEP   = 2'd2,
    PS_WAKING  = 2'd3
  } pwr_state_e;

  // sector index width and the number of upper address bits the map needs
  localparam int SECT_W   = 5;
  localparam int MAP_BITS = 7;

  // round a nanosecond delay up to whole clock cycles, never below one
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/frp_addr_watch.sv
module frp_addr_watch #(
  parameter int W       = 21,
  parameter int CNT_MAX = 15,
  localparam int CW     = $clog2(CNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  vec,
  input  logic          restart,
  output logic          primed,
  output logic          changed,
  output logic [CW-1:0] stable_cnt
);

  localparam logic [CW-1:0] CNT_TOP = CW'(CNT_MAX);

  logic [W-1:0] prev_q;

  // the first sampled value after reset is a baseline, not a change
  assign changed = primed && (vec != prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= '0;
      primed     <= 1'b0;
      stable_cnt <= '0;
    end else begin
      prev_q <= vec;
      primed <= 1'b1;
      if (restart || changed || !primed)
        stable_cnt <= '0;
      else if (stable_cnt != CNT_TOP)
        stable_cnt <= stable_cnt + 1'b1;
    end
  end

  // R4
  restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    changed |=> (stable_cnt == '0));

endmodule

// File: rtl/frp_oe_delay.sv
module frp_oe_delay #(
  parameter int OE_CYC = 3,
  localparam int CW    = $clog2(OE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic ready
);

  localparam logic [CW-1:0] CNT_TOP = CW'(OE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!en)
      cnt_q <= '0;
    else if (cnt_q != CNT_TOP)
      cnt_q <= cnt_q + 1'b1;
  end

  assign ready = (cnt_q == CNT_TOP);

  // R3
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> $past(en));

endmodule

// File: rtl/frp_sector_map.sv
module frp_sector_map
  import frp_pkg::*;
#(
  parameter bit BOOT_TOP = 1'b1
) (
  input  logic [MAP_BITS-1:0] hi_bits,
  output logic [SECT_W-1:0]   sector_idx
);

  logic [3:0] slot;
  logic [2:0] sub;

  // upper four bits pick one of 16 equal slots; next three split the boot slot in eighths
  assign slot = hi_bits[MAP_BITS-1 -: 4];
  assign sub  = hi_bits[2:0];

  generate
    if (BOOT_TOP) begin : g_top_boot
      always_comb begin
        if (slot == 4'hF) begin
          case (sub)
            3'd0, 3'd1, 3'd2, 3'd3: sector_idx = SECT_W'(15);
            3'd4:                   sector_idx = SECT_W'(16);
            3'd5:                   sector_idx = SECT_W'(17);
            default:                sector_idx = SECT_W'(18);
          endcase
        end else begin
          sector_idx = {1'b0, slot};
        end
      end
    end else begin : g_bot_boot
      always_comb begin
        if (slot == 4'h0) begin
          case (sub)
            3'd0, 3'd1: sector_idx = SECT_W'(0);
            3'd2:       sector_idx = SECT_W'(1);
            3'd3:       sector_idx = SECT_W'(2);
            default:    sector_idx = SECT_W'(3);
          endcase
        end else begin
          sector_idx = {1'b0, slot} + SECT_W'(3);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/flash_read_pm.sv
module flash_read_pm
  import frp_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_ACC_NS      = 70,
  parameter int T_OE_NS       = 30,
  parameter int T_RH_NS       = 50,
  parameter int T_SLEEP_NS    = 150,
  parameter bit BOOT_TOP      = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel,
  input  logic              out_en,
  input  logic              dev_rst_n,
  input  logic              byte_mode,
  input  logic [ADDR_W:0]   addr,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              data_valid,
  output logic [1:0]        pwr_state,
  output logic [SECT_W-1:0] sector_idx
);

  localparam int ACC_CYC = ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS);
  localparam int OE_CYC  = ns_to_cyc(T_OE_NS, CLK_PERIOD_NS);
  localparam int RH_CYC  = ns_to_cyc(T_RH_NS, CLK_PERIOD_NS);
  localparam int SLP_CYC = ns_to_cyc(T_SLEEP_NS, CLK_PERIOD_NS);
  localparam int CNT_W   = $clog2(SLP_CYC + 1);
  localparam int RH_W    = $clog2(RH_CYC + 1);
  localparam int LANE_W  = DATA_W / 2;
  localparam int VEC_W   = ADDR_W + 2;

  localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] SLP_LAST = CNT_W'(SLP_CYC - 1);
  localparam logic [RH_W-1:0]  RH_LAST  = RH_W'(RH_CYC - 1);

  pwr_state_e        state_q;
  logic              rh_pend_q;
  logic [RH_W-1:0]   wake_cnt_q;
  logic              data_ok_q;
  logic              armed_q;
  logic              cs_prev_q;
  logic [DATA_W-1:0] dq_q;

  logic              primed;
  logic              changed;
  logic [CNT_W-1:0]  stable_cnt;
  logic              oe_ready;
  logic [VEC_W-1:0]  watch_vec;
  logic [DATA_W-1:0] rd_fmt;
  logic              lane_hi;
  logic              in_access;
  logic              cs_toggled;

  // ---------------- address path ----------------
  assign mem_addr  = byte_mode ? addr[ADDR_W:1] : addr[ADDR_W-1:0];
  assign lane_hi   = byte_mode & addr[0];
  // in word mode the lane bit position above the word address is ignored
  assign watch_vec = {byte_mode, byte_mode ? addr : {1'b0, addr[ADDR_W-1:0]}};

  always_comb begin
    if (byte_mode)
      rd_fmt = {{(DATA_W - LANE_W){1'b0}},
                lane_hi ? mem_rdata[DATA_W-1:LANE_W] : mem_rdata[LANE_W-1:0]};
    else
      rd_fmt = mem_rdata;
  end

  assign in_access = (state_q == PS_ACTIVE) || (state_q == PS_SLEEP);

  frp_addr_watch #(
    .W       (VEC_W),
    .CNT_MAX (SLP_CYC)
  ) u_watch (
    .clk        (clk),
    .rst_n      (rst_n),
    .vec        (watch_vec),
    .restart    (!in_access),
    .primed     (primed),
    .changed    (changed),
    .stable_cnt (stable_cnt)
  );

  frp_oe_delay #(
    .OE_CYC (OE_CYC)
  ) u_oe (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (out_en & chip_sel),
    .ready (oe_ready)
  );

  frp_sector_map #(
    .BOOT_TOP (BOOT_TOP)
  ) u_map (
    .hi_bits    (mem_addr[ADDR_W-1 -: MAP_BITS]),
    .sector_idx (sector_idx)
  );

  // ---------------- power-state machine ----------------
  assign cs_toggled = primed && (chip_sel != cs_prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PS_STANDBY;
      rh_pend_q  <= 1'b0;
      wake_cnt_q <= '0;
      data_ok_q  <= 1'b0;
      armed_q    <= 1'b0;
      cs_prev_q  <= 1'b0;
      dq_q       <= '0;
    end else begin
      cs_prev_q <= chip_sel;
      if (!dev_rst_n || cs_toggled || changed)
        armed_q <= 1'b1;

      if (!dev_rst_n) begin
        state_q   <= PS_STANDBY;
        rh_pend_q <= 1'b1;
        data_ok_q <= 1'b0;
      end else begin
        unique case (state_q)
          PS_STANDBY: begin
            if (rh_pend_q) begin
              state_q    <= PS_WAKING;
              wake_cnt_q <= '0;
              rh_pend_q  <= 1'b0;
            end else if (chip_sel) begin
              state_q <= PS_ACTIVE;
            end
          end
          PS_WAKING: begin
            if (wake_cnt_q == RH_LAST)
              state_q <= chip_sel ? PS_ACTIVE : PS_STANDBY;
            else
              wake_cnt_q <= wake_cnt_q + 1'b1;
          end
          PS_ACTIVE: begin
            if (!chip_sel) begin
              state_q   <= PS_STANDBY;
              data_ok_q <= 1'b0;
            end else if (changed) begin
              data_ok_q <= 1'b0;
            end else if (!data_ok_q && armed_q && stable_cnt == ACC_LAST) begin
              data_ok_q <= 1'b1;
              dq_q      <= rd_fmt;
            end else if (data_ok_q && stable_cnt == SLP_LAST) begin
              state_q <= PS_SLEEP;
            end
          end
          PS_SLEEP: begin
            if (!chip_sel) begin
              state_q   <= PS_STANDBY;
              data_ok_q <= 1'b0;
            end else if (changed) begin
              state_q   <= PS_ACTIVE;
              data_ok_q <= 1'b0;
            end
          end
          default: state_q <= PS_STANDBY;
        endcase
      end
    end
  end

  // ---------------- outputs ----------------
  assign pwr_state  = state_q;
  assign data_valid = data_ok_q;
  assign dq_out     = dq_q;
  assign dq_oe      = data_ok_q && oe_ready && out_en && chip_sel && dev_rst_n;

  // ---------------- assertions ----------------
  // R2
  oe_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (data_ok_q && in_access));

  // R5
  standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_STANDBY) |-> (!dq_oe && !data_valid));

  // R6
  wake_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_WAKING) |-> !data_ok_q);

  // R6
  wake_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_WAKING && $past(state_q) != PS_WAKING) |->
      ($past(state_q) == PS_STANDBY && $past(dev_rst_n)));

  // R7
  sleep_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SLEEP) |-> data_ok_q);

  // R7
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SLEEP && $past(state_q) == PS_SLEEP) |-> $stable(dq_q));

  // R8
  sleep_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SLEEP && changed) |=> (state_q != PS_SLEEP));

  // R9
  unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !data_ok_q);

endmodule

// File: tb/tb_flash_read_pm.sv
module tb_flash_read_pm;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 19;
  localparam int DW  = 16;
  localparam int ACC = (70 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int OE  = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int RH  = (50 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int SLP = (150 + CLK_PERIOD - 1) / CLK_PERIOD;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chip_sel = 1'b0;
  logic          out_en = 1'b0;
  logic          dev_rst_n = 1'b1;
  logic          byte_mode = 1'b0;
  logic [AW:0]   addr = '0;
  logic [AW-1:0] mem_addr, mem_addr_b;
  logic [DW-1:0] mem_rdata, mem_rdata_b;
  logic [DW-1:0] dq_out, dq_out_b;
  logic          dq_oe, dq_oe_b, data_valid, data_valid_b;
  logic [1:0]    pwr_state, pwr_state_b;
  logic [4:0]    sector_idx, sector_idx_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [DW-1:0] memfn(input logic [AW-1:0] w);
    return w[15:0] ^ {w[18:16], 13'h0} ^ 16'h5A3C;
  endfunction

  function automatic logic [AW-1:0] word_of(input logic bm, input logic [AW:0] a);
    return bm ? a[AW:1] : a[AW-1:0];
  endfunction

  function automatic logic [DW-1:0] exp_out(input logic bm, input logic [AW:0] a);
    logic [DW-1:0] w;
    w = memfn(word_of(bm, a));
    if (!bm) return w;
    return a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  function automatic int sect_bot(input logic [AW-1:0] w);
    if (w < 19'h02000) return 0;
    if (w < 19'h03000) return 1;
    if (w < 19'h04000) return 2;
    if (w < 19'h08000) return 3;
    return 3 + int'(w >> 15);
  endfunction

  function automatic int sect_top(input logic [AW-1:0] w);
    if (w < 19'h78000) return int'(w >> 15);
    if (w < 19'h7C000) return 15;
    if (w < 19'h7D000) return 16;
    if (w < 19'h7E000) return 17;
    return 18;
  endfunction

  assign mem_rdata   = memfn(mem_addr);
  assign mem_rdata_b = memfn(mem_addr_b);

  flash_read_pm #(.BOOT_TOP(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .out_en(out_en),
    .dev_rst_n(dev_rst_n), .byte_mode(byte_mode), .addr(addr),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .dq_out(dq_out),
    .dq_oe(dq_oe), .data_valid(data_valid), .pwr_state(pwr_state),
    .sector_idx(sector_idx)
  );

  flash_read_pm #(.BOOT_TOP(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .out_en(out_en),
    .dev_rst_n(dev_rst_n), .byte_mode(byte_mode), .addr(addr),
    .mem_addr(mem_addr_b), .mem_rdata(mem_rdata_b), .dq_out(dq_out_b),
    .dq_oe(dq_oe_b), .data_valid(data_valid_b), .pwr_state(pwr_state_b),
    .sector_idx(sector_idx_b)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk_sectors(input string tag);
    logic [AW-1:0] w;
    w = word_of(byte_mode, addr);
    chk(sector_idx == 5'(sect_top(w)), tag, 32'(sector_idx), 32'(sect_top(w)));
    chk(sector_idx_b == 5'(sect_bot(w)), tag, 32'(sector_idx_b), 32'(sect_bot(w)));
  endtask

  logic [AW-1:0] bnd [18] = '{19'h00000, 19'h01FFF, 19'h02000, 19'h02FFF,
                              19'h03000, 19'h03FFF, 19'h04000, 19'h07FFF,
                              19'h08000, 19'h77FFF, 19'h78000, 19'h7BFFF,
                              19'h7C000, 19'h7CFFF, 19'h7D000, 19'h7DFFF,
                              19'h7E000, 19'h7FFFF};

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    logic [AW:0] na;
    logic nb;
    int extra;
    logic [DW-1:0] held;
    sd = $urandom(32'd2024);

    // power-up with select and enable held, address steady
    chip_sel = 1'b1; out_en = 1'b1; addr = 20'h00123;
    step(2);
    // R1
    chk(pwr_state == 2'd1, "R1 state", 32'(pwr_state), 1);
    chk(!data_valid && !dq_oe, "R1 outputs", {data_valid, dq_oe}, 0);
    rst_n = 1'b1;
    step(1);
    chk(!data_valid, "R1 after release", 32'(data_valid), 0);
    step(ACC + SLP);
    // R9: no valid data at unchanged address, and no sleep without it (R7)
    chk(!data_valid, "R9 unarmed", 32'(data_valid), 0);
    chk(pwr_state == 2'd0, "R7 no sleep unarmed", 32'(pwr_state), 0);

    // R4: address change starts a read
    addr = 20'h04567;
    step(1); step(ACC - 1);
    chk(!data_valid, "R4 early", 32'(data_valid), 0);
    step(1);
    chk(data_valid, "R4 valid", 32'(data_valid), 1);
    chk(dq_out == exp_out(0, addr), "R4 data", 32'(dq_out), 32'(exp_out(0, addr)));
    chk(dq_oe, "R2 drive", 32'(dq_oe), 1);

    // R2 / R3: output enable gating and delay
    out_en = 1'b0; #1;
    chk(!dq_oe, "R2 oe low", 32'(dq_oe), 0);
    step(2);
    out_en = 1'b1;
    step(OE - 1);
    chk(!dq_oe, "R3 early", 32'(dq_oe), 0);
    step(1);
    chk(dq_oe, "R3 on time", 32'(dq_oe), 1);

    // R7: sleep after stable address
    addr = 20'h1A0F0;
    step(1); step(SLP - 1);
    chk(pwr_state == 2'd0, "R7 before", 32'(pwr_state), 0);
    step(1);
    chk(pwr_state == 2'd2, "R7 sleep", 32'(pwr_state), 2);
    chk(data_valid && dq_oe, "R7 outputs", {data_valid, dq_oe}, 3);
    held = dq_out;
    step(6);
    chk(pwr_state == 2'd2 && dq_out == held, "R7 hold", 32'(dq_out), 32'(held));
    chk(held == exp_out(0, addr), "R7 data", 32'(held), 32'(exp_out(0, addr)));

    // R8: address change cancels sleep
    addr = 20'h2BCDE;
    step(1);
    chk(pwr_state == 2'd0, "R8 wake", 32'(pwr_state), 0);
    chk(!data_valid, "R8 invalid", 32'(data_valid), 0);
    step(ACC - 1);
    chk(!data_valid, "R8 early", 32'(data_valid), 0);
    step(1);
    chk(data_valid && dq_out == exp_out(0, addr), "R8 data", 32'(dq_out),
        32'(exp_out(0, addr)));

    // R10: byte mode lanes and address mapping
    byte_mode = 1'b1; addr = {19'h3C3C3, 1'b1}; #1;
    chk(mem_addr == 19'h3C3C3, "R10 byte addr", 32'(mem_addr), 32'h3C3C3);
    step(1 + ACC);
    chk(dq_out == exp_out(1, addr), "R10 high lane", 32'(dq_out), 32'(exp_out(1, addr)));
    addr = {19'h3C3C3, 1'b0};
    step(1 + ACC);
    chk(dq_out == exp_out(1, addr), "R10 low lane", 32'(dq_out), 32'(exp_out(1, addr)));
    byte_mode = 1'b0; addr = 20'h05555; #1;
    chk(mem_addr == 19'h05555, "R10 word addr", 32'(mem_addr), 32'h05555);
    step(1 + ACC);

    // R5: deselect gives standby
    chip_sel = 1'b0; #1;
    chk(!dq_oe, "R2 cs low", 32'(dq_oe), 0);
    step(1);
    chk(pwr_state == 2'd1 && !data_valid, "R5 standby", 32'(pwr_state), 1);
    chip_sel = 1'b1;
    step(1);
    chk(pwr_state == 2'd0, "R5 reselect", 32'(pwr_state), 0);
    step(ACC - 1);
    chk(!data_valid, "R5 early", 32'(data_valid), 0);
    step(1);
    chk(data_valid, "R5 valid", 32'(data_valid), 1);

    // R6: device reset standby and wake-up
    dev_rst_n = 1'b0; #1;
    chk(!dq_oe, "R2 reset low", 32'(dq_oe), 0);
    step(1);
    chk(pwr_state == 2'd1, "R6 standby", 32'(pwr_state), 1);
    step(2);
    dev_rst_n = 1'b1;
    step(1);
    chk(pwr_state == 2'd3, "R6 waking", 32'(pwr_state), 3);
    step(RH - 1);
    chk(pwr_state == 2'd3 && !data_valid, "R6 still waking", 32'(pwr_state), 3);
    step(1);
    chk(pwr_state == 2'd0, "R6 active", 32'(pwr_state), 0);
    step(ACC - 1);
    chk(!data_valid, "R6 early", 32'(data_valid), 0);
    step(1);
    chk(data_valid, "R6 valid", 32'(data_valid), 1);

    // R9: second power-up, armed only by a device-reset pulse
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(ACC + 4);
    chk(!data_valid, "R9 unarmed again", 32'(data_valid), 0);
    dev_rst_n = 1'b0;
    step(2);
    dev_rst_n = 1'b1;
    step(RH + 1);
    chk(pwr_state == 2'd0, "R9 after wake", 32'(pwr_state), 0);
    step(ACC);
    chk(data_valid && dq_out == exp_out(0, addr), "R9 armed data", 32'(dq_out),
        32'(exp_out(0, addr)));

    // R11: directed sector boundaries
    foreach (bnd[i]) begin
      addr = {1'b0, bnd[i]}; #1;
      chk_sectors("R11 boundary");
    end
    step(1);

    // random reads with random hold times (R4, R7, R11)
    for (int it = 0; it < 40; it++) begin
      nb = 1'($urandom_range(0, 1));
      na = 20'($urandom);
      if (!nb) na[AW] = 1'b0;
      if (nb == byte_mode && na == addr) na = na ^ 20'h2;
      byte_mode = nb; addr = na;
      extra = int'($urandom_range(0, 12));
      #1;
      chk_sectors("R11 random");
      step(1 + ACC + extra);
      chk(data_valid && dq_out == exp_out(nb, na), "R4 random data", 32'(dq_out),
          32'(exp_out(nb, na)));
      chk(pwr_state == ((ACC + extra >= SLP) ? 2'd2 : 2'd0), "R7 random state",
          32'(pwr_state), (ACC + extra >= SLP) ? 2 : 0);
      chk(dq_oe, "R2 random drive", 32'(dq_oe), 1);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule